// File: doc/BRIEF.md
# USB Transmit Bit Stuffer

This block sits in a USB transmit path just ahead of the NRZI encoder. It takes bytes one at a time over a valid/ready handshake and sends them out least significant bit first, one bit per bus clock. Whenever six one bits in a row have left the block, it sends a forced zero on the next clock. During that clock the byte shift register is frozen, so the data bit that was waiting goes out one clock later. Because of that stall, how often the block takes a byte depends on the data and is not a fixed eight-clock rhythm.

The one-run tracker comes in two variants, chosen by a parameter. One keeps a saturating run counter. The other keeps a shift register of the most recent output bits. Both give the same output stream. A start-of-packet pulse clears the run state so that ones at the end of one packet cannot cause a stuff in the next.

Top module: `usb_bit_stuffer`

## Requirements
- R1: After reset, `bit_valid_o` is 0 and `byte_ready_o` is 1.
- R2: A byte accepted with no stuffing in effect is output over eight consecutive clocks, bit 0 first and bit 7 last, with `bit_valid_o` high.
- R3: After six consecutive valid output bits equal to 1, the next valid output bit is a 0 that does not come from the data.
- R4: On a clock that outputs an inserted zero, the pending data bit is held and goes out on the next clock, and `byte_ready_o` is 0.
- R5: An inserted zero ends the run. A run of twelve data ones therefore comes out as six ones, a zero, six ones and a zero.
- R6: `byte_ready_o` is 1 when the block is idle, or when it is outputting the last bit of a byte without a stall. A byte offered on that clock is taken, and its bit 0 follows on the next clock with no gap.
- R7: A one-clock pulse on `sop_i` clears the count of consecutive ones, so ones sent before the pulse do not add to a run after it.
- R8: If the sixth consecutive one is the last data bit, an inserted zero is still output, with `bit_valid_o` high, before the block goes idle.
- R9: `byte_i` has no effect while `byte_ready_o` is 0. Only the value present on the accepting clock is serialized.
- R10: The counter and history tracker variants produce identical `bit_o`, `bit_valid_o` and `byte_ready_o` sequences for the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_i | input | 1 | Start of packet; clears the ones run state |
| byte_i | input | DATA_W | Byte to serialize |
| byte_valid_i | input | 1 | `byte_i` is offered |
| byte_ready_o | output | 1 | A byte offered on this clock is taken |
| bit_o | output | 1 | Serial bit, with stuffing applied, going to the NRZI stage |
| bit_valid_o | output | 1 | `bit_o` carries a bit on this clock |

## Verification
The assertions count consecutive valid ones at the ports. They assume `sop_i` is raised only when a packet begins, and that run state cleared by it is meant to restart counting from zero. The bench honours this by pulsing `sop_i` only when the stream has gone idle. It keeps `byte_valid_i` steady in its meaning but drives junk on `byte_i` while ready is low, to show that the data bus is ignored then. Byte offers with and without idle gaps exercise both the gapless handover and the path through idle.

// File: rtl/usb_stuff_pkg.sv
package usb_stuff_pkg;
  typedef enum logic {TRK_COUNTER = 1'b0, TRK_HISTORY = 1'b1} trk_style_e;
  localparam int unsigned DATA_W_DEF  = 8;
  localparam int unsigned RUN_LEN_DEF = 6;
endpackage

// File: rtl/stuff_data_sreg.sv
module stuff_data_sreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              empty_o,
  output logic              last_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= CNT_W'(DATA_W);
    end else if (shift_i) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o   = sh_q[0];
  assign empty_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/stuff_run_tracker.sv
module stuff_run_tracker #(
  parameter int unsigned             RUN_LEN = 6,
  parameter usb_stuff_pkg::trk_style_e STYLE = usb_stuff_pkg::TRK_COUNTER
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  logic bit_i,
  output logic full_o
);
  generate
    if (STYLE == usb_stuff_pkg::TRK_COUNTER) begin : g_counter
      localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);
      logic [RUN_W-1:0] run_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      run_q <= '0;
        else if (clr_i)   run_q <= '0;
        else if (adv_i) begin
          if (!bit_i)                          run_q <= '0;
          else if (run_q != RUN_W'(RUN_LEN))   run_q <= run_q + 1'b1;
        end
      end
      assign full_o = (run_q == RUN_W'(RUN_LEN));
    end else begin : g_history
      logic [RUN_LEN-1:0] hist_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (clr_i)   hist_q <= '0;
        else if (adv_i)   hist_q <= {hist_q[RUN_LEN-2:0], bit_i};
      end
      assign full_o = &hist_q;
    end
  endgenerate
endmodule

// File: rtl/usb_bit_stuffer.sv
module usb_bit_stuffer #(
  parameter int unsigned               DATA_W    = usb_stuff_pkg::DATA_W_DEF,
  parameter int unsigned               RUN_LEN   = usb_stuff_pkg::RUN_LEN_DEF,
  parameter usb_stuff_pkg::trk_style_e TRK_STYLE = usb_stuff_pkg::TRK_COUNTER
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sop_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              bit_o,
  output logic              bit_valid_o
);
  logic stuff, busy, data_bit, empty, last, load, shift;

  stuff_data_sreg #(.DATA_W(DATA_W)) u_sreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  (byte_i),
    .shift_i (shift),
    .bit_o   (data_bit),
    .empty_o (empty),
    .last_o  (last)
  );

  stuff_run_tracker #(.RUN_LEN(RUN_LEN), .STYLE(TRK_STYLE)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sop_i),
    .adv_i  (bit_valid_o),
    .bit_i  (bit_o),
    .full_o (stuff)
  );

  assign busy         = !empty;
  assign shift        = busy && !stuff;     // frozen on an inserted zero
  assign bit_valid_o  = busy || stuff;
  assign bit_o        = stuff ? 1'b0 : data_bit;
  assign byte_ready_o = !stuff && (empty || last);
  assign load         = byte_valid_i && byte_ready_o;
endmodule

// File: rtl/usb_bit_stuffer_chk.sv
module usb_bit_stuffer_chk #(
  parameter int unsigned RUN_LEN = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sop_i,
  input logic byte_valid_i,
  input logic byte_ready_o,
  input logic bit_o,
  input logic bit_valid_o
);
  logic [7:0] ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ones_q <= '0;
    else if (sop_i)        ones_q <= '0;
    else if (bit_valid_o)  ones_q <= bit_o ? ((ones_q == 8'hff) ? ones_q : ones_q + 1'b1) : '0;
  end

  p_zero_after_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ones_q == 8'(RUN_LEN)) && bit_valid_o |-> !bit_o);
  p_run_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= 8'(RUN_LEN));
  p_stall_no_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ones_q == 8'(RUN_LEN)) |-> !byte_ready_o);
  p_tail_stuff_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ones_q == 8'(RUN_LEN)) |-> bit_valid_o);
  p_idle_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_o |-> byte_ready_o);
  p_gapless_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && byte_ready_o |=> bit_valid_o);
endmodule

bind usb_bit_stuffer usb_bit_stuffer_chk #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sop_i        (sop_i),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .bit_o        (bit_o),
  .bit_valid_o  (bit_valid_o)
);

// File: tb/tb_usb_bit_stuffer.sv
module tb_usb_bit_stuffer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sop = 1'b0;
  logic [7:0] din = '0;
  logic       dvalid = 1'b0;
  logic       rdy_c, bit_c, val_c, rdy_h, bit_h, val_h;

  usb_bit_stuffer dut (
    .clk_i(clk), .rst_ni(rst_n), .sop_i(sop), .byte_i(din), .byte_valid_i(dvalid),
    .byte_ready_o(rdy_c), .bit_o(bit_c), .bit_valid_o(val_c));

  usb_bit_stuffer #(.TRK_STYLE(usb_stuff_pkg::TRK_HISTORY)) dut_h (
    .clk_i(clk), .rst_ni(rst_n), .sop_i(sop), .byte_i(din), .byte_valid_i(dvalid),
    .byte_ready_o(rdy_h), .bit_o(bit_h), .bit_valid_o(val_h));

  int         checks = 0, errors = 0;
  bit         mq[$];
  logic [7:0] txq[$];
  int         run = 0;
  int         gap_set = 0, gap_left = 0;
  bit         garbage = 0, sop_req = 0, acc = 0;
  string      req = "R1";

  function automatic bit m_stuff();  return run == 6; endfunction
  function automatic bit m_valid();  return m_stuff() || mq.size() > 0; endfunction
  function automatic bit m_bit();    return m_stuff() ? 1'b0 : mq[0]; endfunction
  function automatic bit m_ready();  return !m_stuff() && mq.size() <= 1; endfunction

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", r, what, act, exp, $time);
    end
  endtask

  // compare, then drive
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req, "bit_valid", val_c, m_valid());
      chk(req, "byte_ready", rdy_c, m_ready());
      if (m_valid()) chk(req, "bit", bit_c, m_bit());
      chk("R10", "hist bit_valid", val_h, m_valid());
      chk("R10", "hist byte_ready", rdy_h, m_ready());
      if (m_valid()) chk("R10", "hist bit", bit_h, m_bit());
      sop = sop_req;
      sop_req = 0;
      acc = 0;
      if (txq.size() > 0 && gap_left == 0) begin
        dvalid = 1'b1;
        din = (m_ready() || !garbage) ? txq[0] : ~txq[0] ^ 8'(checks);
        acc = m_ready();
      end else begin
        dvalid = 1'b0;
        din = garbage ? 8'(checks) : 8'h00;
        if (gap_left > 0) gap_left--;
      end
    end
  end

  // model update
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); run = 0;
    end else begin
      automatic bit st = m_stuff();
      automatic bit v  = m_valid();
      automatic bit b  = m_bit();
      if (sop)    run = 0;
      else if (v) run = b ? run + 1 : 0;
      if (!st && mq.size() > 0) void'(mq.pop_front());
      if (acc) begin
        for (int i = 0; i < 8; i++) mq.push_back(txq[0][i]);
        void'(txq.pop_front());
        gap_left = gap_set;
      end
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (txq.size() > 0 || mq.size() > 0 || run == 6 || acc);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=hung exp=idle");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1", "reset bit_valid", val_c, 0);
    chk("R1", "reset byte_ready", rdy_c, 1);
    @(negedge clk);
    #2 rst_n = 1'b1;

    req = "R2"; txq.push_back(8'hA5); txq.push_back(8'h3C); txq.push_back(8'h81); wait_idle();
    req = "R3"; txq.push_back(8'hFF); txq.push_back(8'h00); wait_idle();
    req = "R4"; txq.push_back(8'h3F); txq.push_back(8'h55); wait_idle();
    req = "R5"; txq.push_back(8'hFF); txq.push_back(8'h0F); txq.push_back(8'hFF); txq.push_back(8'hFF); wait_idle();
    req = "R8"; sop_req = 1; @(negedge clk); txq.push_back(8'hFC); wait_idle();
    req = "R7"; sop_req = 1; @(negedge clk); txq.push_back(8'hE0); wait_idle();
    sop_req = 1; @(negedge clk); txq.push_back(8'hFF); wait_idle();
    // without the clear, the trailing ones carry over
    txq.push_back(8'hE0); wait_idle(); txq.push_back(8'h07); wait_idle();
    req = "R6"; gap_set = 3; txq.push_back(8'h7E); txq.push_back(8'hFE); txq.push_back(8'h01); wait_idle();
    gap_set = 0; txq.push_back(8'hC3); txq.push_back(8'hFF); wait_idle();
    req = "R9"; garbage = 1; txq.push_back(8'hF0); txq.push_back(8'hFF); txq.push_back(8'h3F); txq.push_back(8'h9A); wait_idle();
    garbage = 0;
    req = "R10"; for (int i = 0; i < 40; i++) txq.push_back(8'((i * 37 + 11) ^ (i << 5))); wait_idle();
    summary();
  end
endmodule